// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Loader

This block is the serial front end of one device in a chain of devices that take their configuration from a single shared bit stream. Bits arrive on `din` and are sampled on the rising edge of `cclk`. The block hunts for a fixed start pattern and then captures a stream length field. It repeats both on `dout` so that every device further down the chain sees them as well. It then fills its own configuration memory one frame at a time through a simple write port. While it does this, it holds `dout` high, so a downstream device never sees a frame start bit. Once its memory is full, it passes every further bit straight through to `dout`.

A single bit counter runs from the first bit of the start pattern to the end of the stream. When that counter equals the captured length, the block raises `done` and keeps it high until the next reset. All logic runs on the rising edge of `cclk`, except the final output flop, which updates `dout` on the falling edge. This gives the next device half a cycle of setup before it samples.

The controller steps through six states. IDLE moves to PREAMBLE on a 0 bit. PREAMBLE moves to LENGTH when all four pattern bits match, and falls back to IDLE on any mismatch. LENGTH moves to LOAD after the 24th length bit. LOAD moves to FORWARD when the last local frame completes, or directly to DONE if the counter reaches the length first. FORWARD moves to DONE when the counter reaches the length. DONE is left only through `rst` or a low `init_n`, both of which return the block to IDLE.

Top module: `serial_chain_loader`

## Requirements
- R1: A high `rst` or a low `init_n` at a rising edge returns the block to IDLE. It clears the bit counter, the frame address, `frame_error` and `done`. From the following falling edge, `dout` is 1.
- R2: The start pattern is the 4 bits 0,0,1,0, in time order, following idle 1s. A mismatched bit returns the block to IDLE with the counter cleared, so a later correct pattern is still found.
- R3: The 24 bits that follow the pattern are captured as the stream length, most significant bit first.
- R4: Every bit sampled in IDLE, PREAMBLE or LENGTH appears on `dout` from the falling edge that follows its sampling edge.
- R5: Every bit sampled in LOAD gives `dout` = 1.
- R6: In LOAD, a frame is a 0 start bit, 64 data bits and 3 stop bits. The first data bit lands in `cfg_data[63]`. 1 bits between frames are ignored. Each frame gives exactly one `cfg_wr` pulse, visible after the sampling edge of its last stop bit, with `cfg_addr` counting 0, 1, 2, 3.
- R7: A 0 in any stop bit sets `frame_error`, which stays 1 until R1 clears it. The frame is still written.
- R8: After the 4th frame has been written, every further bit appears on `dout` as in R4, and no further `cfg_wr` pulse occurs.
- R9: The bit counter counts from the first pattern bit. `done` rises at the rising edge that samples the bit whose count equals the length, in LOAD or FORWARD alike. It then stays high until R1 applies.
- R10: Once `done` is high, further input produces `dout` = 1, no write and no change of `frame_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration bit clock |
| rst | input | 1 | Synchronous reset, active high |
| init_n | input | 1 | Synchronous restart, active low |
| din | input | 1 | Serial stream input |
| dout | output | 1 | Serial stream output to the next device, updated on the falling edge |
| cfg_wr | output | 1 | One-cycle write strobe per completed local frame |
| cfg_addr | output | 2 | Frame address of the write |
| cfg_data | output | 64 | Frame payload of the write |
| frame_error | output | 1 | Sticky stop-bit error flag |
| done | output | 1 | Length reached, held until reset |

## Verification
The bound checker watches on every cycle that `done` stays high once set and that it blocks any later write. It also checks that `dout` is high in the cycles after completion, that `frame_error` is sticky, that write strobes are single pulses, and that write addresses step from zero without passing the memory depth. Only the bench scenarios can show the bit-by-bit relation between `din` and `dout` in each state. The same holds for recovery from a broken start pattern, the exact bit at which `done` rises for a long and a short length, and the address restart after `init_n`.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PREAMBLE = 3'd1,
        ST_LENGTH   = 3'd2,
        ST_LOAD     = 3'd3,
        ST_FORWARD  = 3'd4,
        ST_DONE     = 3'd5
    } scl_state_e;

endpackage

// File: rtl/scl_bit_counter.sv
// Stream bit counter: starts at 1 on the first pattern bit and flags the
// bit whose count equals the captured length.
module scl_bit_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         start,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_next;

    assign cnt_next = cnt_q + 1'b1;
    assign hit      = inc && (cnt_next == limit);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= W'(1);
        end else if (inc) begin
            cnt_q <= cnt_next;
        end
    end

endmodule

// File: rtl/scl_frame_rx.sv
// Local frame receiver: start bit, data bits (MSB first), stop bits.
// Emits one registered write per frame and raises a sticky stop error.
module scl_frame_rx #(
    parameter int DATA_BITS  = 64,
    parameter int STOP_BITS  = 3,
    parameter int MEM_FRAMES = 4,
    parameter int ADDR_W     = 2
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 bit_i,
    output logic                 full_o,
    output logic                 wr_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 err_o
);

    localparam int FRAME_BODY = DATA_BITS + STOP_BITS;
    localparam int POS_W      = $clog2(FRAME_BODY);
    localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(FRAME_BODY - 1);
    localparam logic [POS_W-1:0]  DATA_END  = POS_W'(DATA_BITS);
    localparam logic [ADDR_W-1:0] LAST_IDX  = ADDR_W'(MEM_FRAMES - 1);

    logic                 busy_q;
    logic [POS_W-1:0]     pos_q;
    logic [DATA_BITS-1:0] sh_q;
    logic [ADDR_W-1:0]    idx_q;
    logic                 in_data;
    logic                 in_stop;
    logic                 frame_end;
    logic                 frame_start;

    always_comb begin
        frame_start = en && !busy_q && !bit_i;
        in_data     = en && busy_q && (pos_q < DATA_END);
        in_stop     = en && busy_q && (pos_q >= DATA_END);
        frame_end   = en && busy_q && (pos_q == LAST_POS);
        full_o      = frame_end && (idx_q == LAST_IDX);
    end

    // frame sequencing
    always_ff @(posedge clk) begin
        if (clr) begin
            busy_q <= 1'b0;
            pos_q  <= '0;
        end else if (frame_start) begin
            busy_q <= 1'b1;
            pos_q  <= '0;
        end else if (frame_end) begin
            busy_q <= 1'b0;
            pos_q  <= '0;
        end else if (en && busy_q) begin
            pos_q  <= pos_q + 1'b1;
        end
    end

    // payload assembly
    always_ff @(posedge clk) begin
        if (clr) begin
            sh_q <= '0;
        end else if (in_data) begin
            sh_q <= {sh_q[DATA_BITS-2:0], bit_i};
        end
    end

    // write port and frame address
    always_ff @(posedge clk) begin
        if (clr) begin
            wr_o   <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
            idx_q  <= '0;
        end else begin
            wr_o <= frame_end;
            if (frame_end) begin
                addr_o <= idx_q;
                data_o <= sh_q;
                idx_q  <= idx_q + 1'b1;
            end
        end
    end

    // sticky stop-bit error
    always_ff @(posedge clk) begin
        if (clr) begin
            err_o <= 1'b0;
        end else if (in_stop && !bit_i) begin
            err_o <= 1'b1;
        end
    end

endmodule

// File: rtl/scl_dout_stage.sv
// Output path: choose the bit on the rising edge, launch it on the falling edge.
module scl_dout_stage (
    input  logic clk,
    input  logic clr,
    input  logic pass_en,
    input  logic bit_i,
    output logic dout_o
);

    logic pass_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            pass_q <= 1'b1;
        end else begin
            pass_q <= pass_en ? bit_i : 1'b1;
        end
    end

    always_ff @(negedge clk) begin
        dout_o <= pass_q;
    end

endmodule

// File: rtl/serial_chain_loader.sv
module serial_chain_loader
    import scl_pkg::*;
#(
    parameter int                  PRE_BITS    = 4,
    parameter logic [PRE_BITS-1:0] PRE_PATTERN = 4'b0010,
    parameter int                  LEN_BITS    = 24,
    parameter int                  DATA_BITS   = 64,
    parameter int                  STOP_BITS   = 3,
    parameter int                  MEM_FRAMES  = 4,
    parameter int                  ADDR_W      = (MEM_FRAMES > 1) ? $clog2(MEM_FRAMES) : 1
) (
    input  logic                 cclk,
    input  logic                 rst,
    input  logic                 init_n,
    input  logic                 din,
    output logic                 dout,
    output logic                 cfg_wr,
    output logic [ADDR_W-1:0]    cfg_addr,
    output logic [DATA_BITS-1:0] cfg_data,
    output logic                 frame_error,
    output logic                 done
);

    localparam int PRE_IW = (PRE_BITS > 1) ? $clog2(PRE_BITS) : 1;
    localparam int LEN_IW = (LEN_BITS > 1) ? $clog2(LEN_BITS) : 1;
    localparam logic [PRE_IW-1:0] LAST_PRE = PRE_IW'(PRE_BITS - 1);
    localparam logic [LEN_IW-1:0] LAST_LEN = LEN_IW'(LEN_BITS - 1);

    scl_state_e state_q;
    scl_state_e state_d;

    logic                clear;
    logic [PRE_IW-1:0]   pre_idx_q;
    logic [PRE_BITS-1:0] pre_left_q;
    logic [LEN_IW-1:0]   len_idx_q;
    logic [LEN_BITS-1:0] len_q;

    logic cnt_start;
    logic cnt_abort;
    logic cnt_inc;
    logic cnt_hit;
    logic load_en;
    logic pass_en;
    logic pre_match;
    logic frames_full;

    assign clear     = rst || !init_n;
    assign pre_match = (din == pre_left_q[PRE_BITS-1]);

    // next-state logic
    always_comb begin
        state_d   = state_q;
        cnt_start = 1'b0;
        cnt_abort = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!din && !PRE_PATTERN[PRE_BITS-1]) begin
                    state_d   = ST_PREAMBLE;
                    cnt_start = 1'b1;
                end
            end
            ST_PREAMBLE: begin
                if (!pre_match) begin
                    state_d   = ST_IDLE;
                    cnt_abort = 1'b1;
                end else if (pre_idx_q == LAST_PRE) begin
                    state_d = ST_LENGTH;
                end
            end
            ST_LENGTH: begin
                if (len_idx_q == LAST_LEN) begin
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (cnt_hit) begin
                    state_d = ST_DONE;
                end else if (frames_full) begin
                    state_d = ST_FORWARD;
                end
            end
            ST_FORWARD: begin
                if (cnt_hit) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: begin
                state_d   = ST_IDLE;
                cnt_abort = 1'b1;
            end
        endcase
    end

    // state register and header capture
    always_ff @(posedge cclk) begin
        if (clear) begin
            state_q    <= ST_IDLE;
            pre_idx_q  <= '0;
            pre_left_q <= '0;
            len_idx_q  <= '0;
            len_q      <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    pre_idx_q  <= PRE_IW'(1);
                    pre_left_q <= PRE_PATTERN << 1;
                    len_idx_q  <= '0;
                end
                ST_PREAMBLE: begin
                    if (pre_match) begin
                        pre_idx_q  <= pre_idx_q + 1'b1;
                        pre_left_q <= pre_left_q << 1;
                    end
                end
                ST_LENGTH: begin
                    len_q     <= {len_q[LEN_BITS-2:0], din};
                    len_idx_q <= len_idx_q + 1'b1;
                end
                default: begin
                    pre_idx_q <= pre_idx_q;
                end
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        cnt_inc = 1'b0;
        load_en = 1'b0;
        pass_en = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                pass_en = 1'b1;
            end
            ST_PREAMBLE: begin
                pass_en = 1'b1;
                cnt_inc = 1'b1;
            end
            ST_LENGTH: begin
                pass_en = 1'b1;
                cnt_inc = 1'b1;
            end
            ST_LOAD: begin
                load_en = 1'b1;
                cnt_inc = 1'b1;
            end
            ST_FORWARD: begin
                pass_en = 1'b1;
                cnt_inc = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                done = 1'b0;
            end
        endcase
    end

    scl_bit_counter #(
        .W (LEN_BITS)
    ) i_counter (
        .clk   (cclk),
        .clr   (clear || cnt_abort),
        .start (cnt_start),
        .inc   (cnt_inc),
        .limit (len_q),
        .hit   (cnt_hit)
    );

    scl_frame_rx #(
        .DATA_BITS  (DATA_BITS),
        .STOP_BITS  (STOP_BITS),
        .MEM_FRAMES (MEM_FRAMES),
        .ADDR_W     (ADDR_W)
    ) i_frame_rx (
        .clk    (cclk),
        .clr    (clear),
        .en     (load_en),
        .bit_i  (din),
        .full_o (frames_full),
        .wr_o   (cfg_wr),
        .addr_o (cfg_addr),
        .data_o (cfg_data),
        .err_o  (frame_error)
    );

    scl_dout_stage i_dout (
        .clk     (cclk),
        .clr     (clear),
        .pass_en (pass_en),
        .bit_i   (din),
        .dout_o  (dout)
    );

endmodule

// File: rtl/scl_loader_chk.sv
module scl_loader_chk #(
    parameter int MEM_FRAMES = 4,
    parameter int ADDR_W     = 2
) (
    input logic              cclk,
    input logic              rst,
    input logic              init_n,
    input logic              dout,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              frame_error,
    input logic              done
);

    logic [ADDR_W:0] wr_cnt;

    always_ff @(posedge cclk) begin
        if (rst || !init_n) begin
            wr_cnt <= '0;
        end else if (cfg_wr) begin
            wr_cnt <= wr_cnt + 1'b1;
        end
    end

    assert_done_sticky_R9: assert property (@(posedge cclk) disable iff (rst || !init_n)
        done |=> done);

    assert_no_write_after_done_R10: assert property (@(posedge cclk) disable iff (rst || !init_n)
        done |=> !cfg_wr);

    assert_dout_high_after_done_R10: assert property (@(posedge cclk) disable iff (rst || !init_n)
        (done && $past(done)) |-> dout);

    assert_error_sticky_R7: assert property (@(posedge cclk) disable iff (rst || !init_n)
        frame_error |=> frame_error);

    assert_write_single_pulse_R6: assert property (@(posedge cclk) disable iff (rst || !init_n)
        cfg_wr |=> !cfg_wr);

    assert_write_addr_order_R6: assert property (@(posedge cclk) disable iff (rst || !init_n)
        cfg_wr |-> (cfg_addr == wr_cnt[ADDR_W-1:0]));

    assert_write_count_bound_R8: assert property (@(posedge cclk) disable iff (rst || !init_n)
        cfg_wr |-> (wr_cnt < (ADDR_W+1)'(MEM_FRAMES)));

endmodule

bind serial_chain_loader scl_loader_chk #(
    .MEM_FRAMES (MEM_FRAMES),
    .ADDR_W     (ADDR_W)
) i_scl_loader_chk (
    .cclk        (cclk),
    .rst         (rst),
    .init_n      (init_n),
    .dout        (dout),
    .cfg_wr      (cfg_wr),
    .cfg_addr    (cfg_addr),
    .frame_error (frame_error),
    .done        (done)
);

// File: tb/test_serial_chain_loader.sv
module test_serial_chain_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_n = 1'b1;
    logic        din = 1'b1;
    logic        dout;
    logic        cfg_wr;
    logic [1:0]  cfg_addr;
    logic [63:0] cfg_data;
    logic        frame_error;
    logic        done;

    int checks = 0;
    int fails = 0;
    int wr_seen = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serial_chain_loader i_serial_chain_loader (
        .cclk        (clk),
        .rst         (rst),
        .init_n      (init_n),
        .din         (din),
        .dout        (dout),
        .cfg_wr      (cfg_wr),
        .cfg_addr    (cfg_addr),
        .cfg_data    (cfg_data),
        .frame_error (frame_error),
        .done        (done)
    );

    always @(negedge clk) if (cfg_wr === 1'b1) wr_seen++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one bit: drive, let the rising edge sample it, check dout after the falling edge
    task automatic send(input logic b, input logic exp_dout, input string req);
        din = b;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(dout === exp_dout, req, "dout", 64'(dout), 64'(exp_dout));
    endtask

    task automatic send_pre();
        send(1'b0, 1'b0, "R2");
        send(1'b0, 1'b0, "R2");
        send(1'b1, 1'b1, "R2");
        send(1'b0, 1'b0, "R2");
    endtask

    task automatic send_len(input logic [23:0] len);
        for (int i = 23; i >= 0; i--) send(len[i], len[i], "R3");
    endtask

    task automatic send_ones(input int n, input logic exp_dout, input string req);
        for (int i = 0; i < n; i++) send(1'b1, exp_dout, req);
    endtask

    task automatic send_frame(input logic [63:0] data, input bit stop_ok,
                              input bit own, input logic [1:0] exp_addr);
        int w0;
        w0 = wr_seen;
        send(1'b0, own ? 1'b1 : 1'b0, own ? "R5" : "R8");
        for (int i = 63; i >= 0; i--) send(data[i], own ? 1'b1 : data[i], own ? "R5" : "R8");
        send(stop_ok ? 1'b1 : 1'b0, own ? 1'b1 : (stop_ok ? 1'b1 : 1'b0), own ? "R7" : "R8");
        send(1'b1, 1'b1, "R6");
        send(1'b1, 1'b1, "R6");
        if (own) begin
            chk(cfg_wr === 1'b1, "R6", "cfg_wr", 64'(cfg_wr), 64'd1);
            chk(cfg_addr === exp_addr, "R6", "cfg_addr", 64'(cfg_addr), 64'(exp_addr));
            chk(cfg_data === data, "R6", "cfg_data", cfg_data, data);
            chk(wr_seen == w0 + 1, "R6", "writes", 64'(wr_seen), 64'(w0 + 1));
        end else begin
            chk(wr_seen == w0, "R8", "writes", 64'(wr_seen), 64'(w0));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        din = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(dout === 1'b1, "R1", "dout", 64'(dout), 64'd1);
        chk(done === 1'b0, "R1", "done", 64'(done), 64'd0);
        chk(cfg_wr === 1'b0, "R1", "cfg_wr", 64'(cfg_wr), 64'd0);
        chk(frame_error === 1'b0, "R1", "frame_error", 64'(frame_error), 64'd0);
    endtask

    // full chain: four own frames, a gap, one forwarded frame, postamble
    task automatic t_full_chain();
        int w0;
        do_reset();
        w0 = wr_seen;
        send_ones(5, 1'b1, "R4");
        send_pre();
        send_len(24'd381);
        send_frame(64'h0123_4567_89AB_CDEF, 1'b1, 1'b1, 2'd0);
        send_frame(64'hFEDC_BA98_7654_3210, 1'b1, 1'b1, 2'd1);
        send_ones(3, 1'b1, "R6");
        chk(wr_seen == w0 + 2, "R6", "gap writes", 64'(wr_seen), 64'(w0 + 2));
        send_frame(64'h8000_0000_0000_0001, 1'b1, 1'b1, 2'd2);
        send_frame(64'h5A5A_0F0F_C3C3_9669, 1'b1, 1'b1, 2'd3);
        send_frame(64'h0000_FFFF_0000_FFFF, 1'b1, 1'b0, 2'd0);
        send_ones(9, 1'b1, "R8");
        chk(done === 1'b0, "R9", "done early", 64'(done), 64'd0);
        send(1'b1, 1'b1, "R8");
        chk(done === 1'b1, "R9", "done at length", 64'(done), 64'd1);
        for (int i = 0; i < 5; i++) send(1'b0, 1'b1, "R10");
        chk(done === 1'b1, "R9", "done held", 64'(done), 64'd1);
        chk(wr_seen == w0 + 4, "R8", "total writes", 64'(wr_seen), 64'(w0 + 4));
        chk(frame_error === 1'b0, "R7", "frame_error clean", 64'(frame_error), 64'd0);
    endtask

    // broken pattern, stop-bit error, length ending inside LOAD
    task automatic t_errors_early();
        int w0;
        do_reset();
        send_ones(3, 1'b1, "R4");
        send(1'b0, 1'b0, "R2");
        send(1'b0, 1'b0, "R2");
        send(1'b1, 1'b1, "R2");
        send(1'b1, 1'b1, "R2");
        send_ones(2, 1'b1, "R4");
        send_pre();
        send_len(24'd101);
        send_frame(64'hDEAD_BEEF_0000_1111, 1'b0, 1'b1, 2'd0);
        chk(frame_error === 1'b1, "R7", "frame_error set", 64'(frame_error), 64'd1);
        send_ones(4, 1'b1, "R5");
        chk(done === 1'b0, "R9", "done early", 64'(done), 64'd0);
        send(1'b1, 1'b1, "R5");
        chk(done === 1'b1, "R9", "done in load", 64'(done), 64'd1);
        w0 = wr_seen;
        send(1'b0, 1'b1, "R10");
        for (int i = 0; i < 64; i++) send(i[0], 1'b1, "R10");
        for (int i = 0; i < 3; i++) send(1'b0, 1'b1, "R10");
        send_ones(2, 1'b1, "R10");
        chk(wr_seen == w0, "R10", "writes after done", 64'(wr_seen), 64'(w0));
        chk(frame_error === 1'b1, "R7", "frame_error held", 64'(frame_error), 64'd1);
    endtask

    // init_n pulse from DONE and in mid-load restarts the address
    task automatic t_init_abort();
        init_n = 1'b0;
        din = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        init_n = 1'b1;
        chk(done === 1'b0, "R1", "done after init_n", 64'(done), 64'd0);
        chk(frame_error === 1'b0, "R1", "frame_error after init_n", 64'(frame_error), 64'd0);
        chk(dout === 1'b1, "R1", "dout after init_n", 64'(dout), 64'd1);
        send_pre();
        send_len(24'd2000);
        send_frame(64'h1111_2222_3333_4444, 1'b1, 1'b1, 2'd0);
        send_frame(64'h5555_6666_7777_8888, 1'b1, 1'b1, 2'd1);
        init_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        init_n = 1'b1;
        chk(done === 1'b0, "R1", "done mid-load", 64'(done), 64'd0);
        send_ones(2, 1'b1, "R4");
        send_pre();
        send_len(24'd101);
        send_frame(64'h9999_AAAA_BBBB_CCCC, 1'b1, 1'b1, 2'd0);
        send_ones(4, 1'b1, "R5");
        send(1'b1, 1'b1, "R5");
        chk(done === 1'b1, "R9", "done after restart", 64'(done), 64'd1);
    endtask

    initial begin
        @(negedge clk);
        #1;
        t_reset();
        t_full_chain();
        t_errors_early();
        t_init_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule